// File: doc/BRIEF.md
# Interrupt Source State Controller

This block manages a bank of interrupt inputs and decides when each one is offered to a downstream presentation unit. Every input is fixed at build time as either a message-type source or a level-type source. For each source the block holds a destination server, a priority, a saved priority and a small set of status flags. Message-type sources react to a rising edge on their line. Level-type sources track the line level. A priority of all ones masks a source.

The presentation unit sends three kinds of message back. A reject returns an offer it could not take. An end-of-interrupt (EOI) retires an offer it has serviced. A resend request starts a scan that walks every source, one per clock, and re-offers the ones that are still owed. Configuration writes change a source's server and priorities. A write can release a message that arrived while the source was masked, and it can re-check a level-type source.

Offers leave through a single valid/ready channel. Each offer carries the server, the global source number (local index plus a base offset) and the priority. Offers waiting at the same time leave lowest index first.

Top module: `isrc_ctrl`

## Requirements
- R1: After reset no offer is valid, and every source has priority all-ones (masked), server zero and all status flags clear. A message-type assertion straight after reset therefore offers nothing.
- R2: On a rising edge of a message-type line, a masked source records a masked-pending flag and offers nothing. An unmasked source queues one offer carrying its server, its number and its priority.
- R3: A level-type source queues one offer when its line changes while it is unmasked, asserted (line high) and not yet sent. It then marks itself sent and offers nothing further until the sent flag clears.
- R4: A reject aimed at a message-type source sets its rejected flag and offers nothing. A reject aimed at a level-type source clears its sent flag and offers nothing by itself.
- R5: A resend request starts a scan that visits local indices 0 to N-1 in ascending order, one per clock, and holds on the current index while an offer is valid and not accepted. A visited message-type source that is rejected clears the flag and queues an offer if it is unmasked, so a second scan re-offers nothing. A visited level-type source applies the R3 rule. A resend request during a scan is ignored. A reject or EOI arriving in the same cycle as the visit is applied first.
- R6: A configuration write stores the server, the priority and the saved priority. A message-type source with masked-pending set and a new unmasked priority clears masked-pending and queues an offer. A level-type source applies the R3 rule. Otherwise the write offers nothing.
- R7: An EOI clears the sent flag of a level-type source and queues no offer. An EOI has no effect on a message-type source: a rejected flag survives it.
- R8: An offer carries source number = local index + OFFSET. Reject and EOI numbers have OFFSET subtracted. Numbers outside OFFSET to OFFSET+N-1 are ignored and never alias onto a source.
- R9: While offer_valid is high and offer_ready is low, the offer's server, number and priority stay stable. An offer completes on a cycle with both high. Queued offers leave lowest local index first.
- R10: A queued offer whose source is reconfigured to the masked priority before it enters the channel is withdrawn. A message-type source then sets masked-pending, so a later unmasking write releases it. A level-type source clears sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_line | input | N_SRC | Interrupt lines, one per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | clog2(N_SRC) | Local index written |
| cfg_server | input | SRV_W | New destination server |
| cfg_prio | input | PRIO_W | New priority (all ones = masked) |
| cfg_saved_prio | input | PRIO_W | New saved priority |
| rej_valid | input | 1 | Reject message strobe |
| rej_num | input | NUM_W | Global number being rejected |
| eoi_valid | input | 1 | EOI message strobe |
| eoi_num | input | NUM_W | Global number being retired |
| resend_req | input | 1 | Start a resend scan |
| offer_valid | output | 1 | Offer present |
| offer_ready | input | 1 | Presentation unit takes the offer |
| offer_server | output | SRV_W | Destination server of the offer |
| offer_num | output | NUM_W | Global source number of the offer |
| offer_prio | output | PRIO_W | Priority of the offer |

## Verification
The assertions check several properties on every cycle. The channel holds still under back-pressure, offered numbers stay in range, nothing masked ever reaches the channel, and masked-pending only coexists with a masked priority. They also follow the scan index: it holds while stalled and steps by one otherwise. What only the bench scenarios show is the sequencing between sources and messages. This covers a rejected message re-offered exactly once per scan, an EOI that leaves a level source silent until its line moves again, out-of-range numbers that do not alias, and a withdrawn offer coming back on unmasking.

// File: rtl/isrc_pkg.sv
package isrc_pkg;
  typedef struct packed {
    logic asserted;  // level seen on the line
    logic sent;      // level source has an outstanding offer
    logic rejected;  // message source was turned away
    logic mpend;     // message arrived while masked
    logic pend;      // offer queued, waiting for the channel
  } src_status_t;
endpackage

// File: rtl/isrc_cell.sv
module isrc_cell
  import isrc_pkg::*;
#(
  parameter int unsigned SRV_W    = 4,
  parameter int unsigned PRIO_W   = 8,
  parameter bit          IS_LEVEL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line,
  input  logic              cfg_hit,
  input  logic [SRV_W-1:0]  cfg_server,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic [PRIO_W-1:0] cfg_saved,
  input  logic              rej_hit,
  input  logic              eoi_hit,
  input  logic              scan_hit,
  input  logic              take,
  output logic              pend,
  output logic [SRV_W-1:0]  server,
  output logic [PRIO_W-1:0] prio
);
  localparam logic [PRIO_W-1:0] MASKED = '1;

  logic [SRV_W-1:0]  srv_q,   srv_d;
  logic [PRIO_W-1:0] prio_q,  prio_d;
  logic [PRIO_W-1:0] saved_q, saved_d;
  src_status_t       st_q,    st_d;
  logic              line_q;
  logic              level_eval;

  always_comb begin
    srv_d   = srv_q;
    prio_d  = prio_q;
    saved_d = saved_q;
    st_d    = st_q;

    if (take) st_d.pend = 1'b0;

    // returned messages first, so a scan visit sees their effect
    if (rej_hit) begin
      if (IS_LEVEL) st_d.sent = 1'b0;
      else          st_d.rejected = 1'b1;
    end
    if (eoi_hit && IS_LEVEL) st_d.sent = 1'b0;

    st_d.asserted = line;

    if (cfg_hit) begin
      srv_d   = cfg_server;
      prio_d  = cfg_prio;
      saved_d = cfg_saved;
      if (!IS_LEVEL && st_d.mpend && (cfg_prio != MASKED)) begin
        st_d.mpend = 1'b0;
        st_d.pend  = 1'b1;
      end
    end

    if (!IS_LEVEL && line && !line_q) begin
      if (prio_d == MASKED) st_d.mpend = 1'b1;
      else                  st_d.pend  = 1'b1;
    end

    if (scan_hit && !IS_LEVEL && st_d.rejected) begin
      st_d.rejected = 1'b0;
      if (prio_d != MASKED) st_d.pend = 1'b1;
    end

    level_eval = IS_LEVEL && (cfg_hit || scan_hit || (line != line_q));
    if (level_eval && (prio_d != MASKED) && st_d.asserted && !st_d.sent) begin
      st_d.sent = 1'b1;
      st_d.pend = 1'b1;
    end

    // a queued offer that became masked is withdrawn
    if (st_d.pend && (prio_d == MASKED)) begin
      st_d.pend = 1'b0;
      if (IS_LEVEL) st_d.sent  = 1'b0;
      else          st_d.mpend = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srv_q   <= '0;
      prio_q  <= MASKED;
      saved_q <= MASKED;
      st_q    <= '0;
      line_q  <= 1'b0;
    end else begin
      srv_q   <= srv_d;
      prio_q  <= prio_d;
      saved_q <= saved_d;
      st_q    <= st_d;
      line_q  <= line;
    end
  end

  assign pend   = st_q.pend;
  assign server = srv_q;
  assign prio   = prio_q;

  AST_MPEND_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    st_q.mpend |-> (prio_q == MASKED)); // R2
  AST_PEND_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    st_q.pend |-> (prio_q != MASKED)); // R10
  AST_SAVED_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hit |=> (saved_q == $past(cfg_saved))); // R6
endmodule

// File: rtl/isrc_scan.sv
module isrc_scan #(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             resend_req,
  input  logic             stall,
  output logic             go,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_SRC - 1);

  logic             act_q, act_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    go    = act_q && !stall;
    if (go) begin
      if (idx_q == LAST) act_d = 1'b0;
      else               idx_d = idx_q + 1'b1;
    end else if (!act_q && resend_req) begin
      act_d = 1'b1;
      idx_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
    end else begin
      act_q <= act_d;
      idx_q <= idx_d;
    end
  end

  assign idx = idx_q;

  AST_SCAN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && stall) |=> (act_q && $stable(idx_q))); // R5
  AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !stall && (idx_q != LAST)) |=> (act_q && (idx_q == IDX_W'($past(idx_q) + 1'b1)))); // R5
endmodule

// File: rtl/isrc_offer.sv
module isrc_offer #(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned SRV_W  = 4,
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned NUM_W  = 12,
  parameter int unsigned OFFSET = 16,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  pend,
  input  logic [SRV_W-1:0]  srv_in  [N_SRC],
  input  logic [PRIO_W-1:0] prio_in [N_SRC],
  output logic [N_SRC-1:0]  take,
  output logic              offer_valid,
  input  logic              offer_ready,
  output logic [SRV_W-1:0]  offer_server,
  output logic [NUM_W-1:0]  offer_num,
  output logic [PRIO_W-1:0] offer_prio
);
  localparam logic [PRIO_W-1:0] MASKED = '1;

  logic             ov_q, ov_d;
  logic [SRV_W-1:0] srv_q;
  logic [NUM_W-1:0] num_q;
  logic [PRIO_W-1:0] prio_q;
  logic             load, found;
  logic [IDX_W-1:0] pick;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        found = 1'b1;
        pick  = IDX_W'(i);
      end
    end
    load = !ov_q || offer_ready;
    take = '0;
    if (load && found) take[pick] = 1'b1;
    ov_d = load ? found : ov_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q   <= 1'b0;
      srv_q  <= '0;
      num_q  <= '0;
      prio_q <= '0;
    end else begin
      ov_q <= ov_d;
      if (load && found) begin
        srv_q  <= srv_in[pick];
        num_q  <= NUM_W'(OFFSET) + NUM_W'(pick);
        prio_q <= prio_in[pick];
      end
    end
  end

  assign offer_valid  = ov_q;
  assign offer_server = srv_q;
  assign offer_num    = num_q;
  assign offer_prio   = prio_q;

  AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_q && !offer_ready) |=> (ov_q && $stable(srv_q) && $stable(num_q) && $stable(prio_q))); // R9
  AST_TAKE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take)); // R9
  AST_NUM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ov_q |-> ((num_q >= NUM_W'(OFFSET)) && (num_q < NUM_W'(OFFSET + N_SRC)))); // R8
  AST_NO_MASKED_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    ov_q |-> (prio_q != MASKED)); // R2
endmodule

// File: rtl/isrc_ctrl.sv
module isrc_ctrl #(
  parameter int unsigned N_SRC      = 8,
  parameter int unsigned SRV_W      = 4,
  parameter int unsigned PRIO_W     = 8,
  parameter int unsigned NUM_W      = 12,
  parameter int unsigned OFFSET     = 16,
  parameter logic [N_SRC-1:0] LEVEL_MASK = 8'hF0,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_line,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [SRV_W-1:0]  cfg_server,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic [PRIO_W-1:0] cfg_saved_prio,
  input  logic              rej_valid,
  input  logic [NUM_W-1:0]  rej_num,
  input  logic              eoi_valid,
  input  logic [NUM_W-1:0]  eoi_num,
  input  logic              resend_req,
  output logic              offer_valid,
  input  logic              offer_ready,
  output logic [SRV_W-1:0]  offer_server,
  output logic [NUM_W-1:0]  offer_num,
  output logic [PRIO_W-1:0] offer_prio
);
  localparam logic [NUM_W-1:0] NUM_LO = NUM_W'(OFFSET);
  localparam logic [NUM_W-1:0] NUM_HI = NUM_W'(OFFSET + N_SRC);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1   <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_s1   <= 1'b1;
      rst_sync <= rst_s1;
    end
  end

  // number decode (R8)
  logic [NUM_W-1:0] rej_off, eoi_off;
  logic             rej_ok, eoi_ok;
  assign rej_off = rej_num - NUM_LO;
  assign eoi_off = eoi_num - NUM_LO;
  assign rej_ok  = rej_valid && (rej_num >= NUM_LO) && (rej_num < NUM_HI);
  assign eoi_ok  = eoi_valid && (eoi_num >= NUM_LO) && (eoi_num < NUM_HI);

  logic              scan_go;
  logic [IDX_W-1:0]  scan_idx;
  logic              stall;
  logic [N_SRC-1:0]  pend, take;
  logic [SRV_W-1:0]  srv_arr  [N_SRC];
  logic [PRIO_W-1:0] prio_arr [N_SRC];

  assign stall = offer_valid && !offer_ready;

  isrc_scan #(.N_SRC(N_SRC)) u_scan (
    .clk        (clk),
    .rst_n      (rst_sync),
    .resend_req (resend_req),
    .stall      (stall),
    .go         (scan_go),
    .idx        (scan_idx)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic cfg_hit, rej_hit, eoi_hit, scan_hit;
    assign cfg_hit  = cfg_we  && (cfg_idx == IDX_W'(i));
    assign rej_hit  = rej_ok  && (rej_off[IDX_W-1:0] == IDX_W'(i));
    assign eoi_hit  = eoi_ok  && (eoi_off[IDX_W-1:0] == IDX_W'(i));
    assign scan_hit = scan_go && (scan_idx == IDX_W'(i));

    isrc_cell #(
      .SRV_W    (SRV_W),
      .PRIO_W   (PRIO_W),
      .IS_LEVEL (LEVEL_MASK[i])
    ) u_cell (
      .clk        (clk),
      .rst_n      (rst_sync),
      .line       (irq_line[i]),
      .cfg_hit    (cfg_hit),
      .cfg_server (cfg_server),
      .cfg_prio   (cfg_prio),
      .cfg_saved  (cfg_saved_prio),
      .rej_hit    (rej_hit),
      .eoi_hit    (eoi_hit),
      .scan_hit   (scan_hit),
      .take       (take[i]),
      .pend       (pend[i]),
      .server     (srv_arr[i]),
      .prio       (prio_arr[i])
    );
  end

  isrc_offer #(
    .N_SRC  (N_SRC),
    .SRV_W  (SRV_W),
    .PRIO_W (PRIO_W),
    .NUM_W  (NUM_W),
    .OFFSET (OFFSET)
  ) u_offer (
    .clk          (clk),
    .rst_n        (rst_sync),
    .pend         (pend),
    .srv_in       (srv_arr),
    .prio_in      (prio_arr),
    .take         (take),
    .offer_valid  (offer_valid),
    .offer_ready  (offer_ready),
    .offer_server (offer_server),
    .offer_num    (offer_num),
    .offer_prio   (offer_prio)
  );

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_sync |=> !offer_valid); // R1
endmodule

// File: tb/isrc_ctrl_tb.sv
module isrc_ctrl_tb;
  localparam int N = 8;
  localparam int OFF = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  irq_line;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [3:0]  cfg_server;
  logic [7:0]  cfg_prio, cfg_saved_prio;
  logic        rej_valid, eoi_valid, resend_req;
  logic [11:0] rej_num, eoi_num;
  logic        offer_valid, offer_ready;
  logic [3:0]  offer_server;
  logic [11:0] offer_num;
  logic [7:0]  offer_prio;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [23:0] exp_q[$];

  always #2 clk = ~clk;

  isrc_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_line(irq_line),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_server(cfg_server),
    .cfg_prio(cfg_prio), .cfg_saved_prio(cfg_saved_prio),
    .rej_valid(rej_valid), .rej_num(rej_num),
    .eoi_valid(eoi_valid), .eoi_num(eoi_num),
    .resend_req(resend_req),
    .offer_valid(offer_valid), .offer_ready(offer_ready),
    .offer_server(offer_server), .offer_num(offer_num), .offer_prio(offer_prio)
  );

  // monitor: compares each completed offer with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && offer_valid && offer_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected offer srv=%0d num=%0d prio=%0d expected none",
                 offer_server, offer_num, offer_prio);
      end else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        if ({offer_server, offer_num, offer_prio} != e) begin
          errors++;
          $display("FAIL R2/R9 offer srv=%0d num=%0d prio=%0d expected srv=%0d num=%0d prio=%0d",
                   offer_server, offer_num, offer_prio, e[23:20], e[19:8], e[7:0]);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic expect_offer(input logic [3:0] s, input int idx, input logic [7:0] p);
    exp_q.push_back({s, 12'(OFF + idx), p});
  endtask

  task automatic cfg(input int idx, input logic [3:0] s, input logic [7:0] p, input logic [7:0] sp);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_server = s; cfg_prio = p; cfg_saved_prio = sp;
    step();
    cfg_we = 0;
  endtask

  task automatic pulse(input logic [7:0] m);
    irq_line = irq_line | m; step();
    irq_line = irq_line & ~m; step();
  endtask

  task automatic reject(input int num);
    rej_valid = 1; rej_num = 12'(num); step(); rej_valid = 0;
  endtask

  task automatic eoi(input int num);
    eoi_valid = 1; eoi_num = 12'(num); step(); eoi_valid = 0;
  endtask

  task automatic resend();
    resend_req = 1; step(); resend_req = 0;
  endtask

  task automatic wait_idle(input string tag);
    repeat (16) step();
    checks++;
    if (exp_q.size() != 0 || offer_valid) begin
      errors++;
      $display("FAIL %s pending=%0d offer_valid=%0b expected pending=0 offer_valid=0",
               tag, exp_q.size(), offer_valid);
    end
  endtask

  initial begin
    rst_n = 0; irq_line = '0; cfg_we = 0; cfg_idx = '0; cfg_server = '0;
    cfg_prio = '0; cfg_saved_prio = '0; rej_valid = 0; rej_num = '0;
    eoi_valid = 0; eoi_num = '0; resend_req = 0; offer_ready = 1;
    repeat (5) step();
    rst_n = 1;
    repeat (3) step();

    // R1: idle after reset, sources masked
    checks++;
    if (offer_valid) begin
      errors++; $display("FAIL R1 offer_valid=%0b expected 0", offer_valid);
    end
    pulse(8'h01);
    wait_idle("R1_masked_after_reset");
    // R6: unmasking releases the masked-pending message
    expect_offer(4'd3, 0, 8'd5);
    cfg(0, 4'd3, 8'd5, 8'd9);
    wait_idle("R6_release_mpend");

    // R6: write without masked-pending offers nothing; R2 normal assertion
    cfg(1, 4'd1, 8'd2, 8'd4);
    wait_idle("R6_no_offer");
    expect_offer(4'd1, 1, 8'd2);
    pulse(8'h02);
    wait_idle("R2_message_offer");

    // R4, R5: reject then resend, once only
    reject(OFF + 1);
    wait_idle("R4_reject_silent");
    expect_offer(4'd1, 1, 8'd2);
    resend();
    wait_idle("R5_resend_reoffer");
    resend();
    wait_idle("R5_second_scan_silent");

    // R8: out-of-range numbers ignored (25 would alias to index 1)
    reject(OFF + N + 1);
    reject(OFF - 1);
    resend();
    wait_idle("R8_out_of_range");

    // R7: EOI leaves a message-type rejected flag in place
    reject(OFF + 1);
    eoi(OFF + 1);
    expect_offer(4'd1, 1, 8'd2);
    resend();
    wait_idle("R7_eoi_message");

    // R3: level-type source 4
    cfg(4, 4'd2, 8'd7, 8'd7);
    wait_idle("R6_level_low");
    expect_offer(4'd2, 4, 8'd7);
    irq_line[4] = 1; step();
    wait_idle("R3_level_rise");
    reject(OFF + 4);
    wait_idle("R4_level_reject");
    expect_offer(4'd2, 4, 8'd7);
    resend();
    wait_idle("R5_level_resend");
    eoi(OFF + 4);
    wait_idle("R7_level_eoi_silent");
    irq_line[4] = 0; step();
    wait_idle("R3_level_fall");
    expect_offer(4'd2, 4, 8'd7);
    irq_line[4] = 1; step();
    wait_idle("R3_level_reraise");
    // R6: masked level source, then unmasked by write
    irq_line[5] = 1; step();
    wait_idle("R3_level_masked");
    expect_offer(4'd6, 5, 8'd3);
    cfg(5, 4'd6, 8'd3, 8'd3);
    wait_idle("R6_level_rule");

    // R9, R5: back-pressure during a scan
    offer_ready = 0;
    reject(OFF + 0);
    reject(OFF + 1);
    expect_offer(4'd3, 0, 8'd5);
    expect_offer(4'd1, 1, 8'd2);
    resend();
    repeat (20) step();
    checks++;
    if (!offer_valid || offer_num != 12'(OFF) || offer_prio != 8'd5) begin
      errors++;
      $display("FAIL R9 valid=%0b num=%0d prio=%0d expected valid=1 num=%0d prio=5",
               offer_valid, offer_num, offer_prio, OFF);
    end
    offer_ready = 1;
    wait_idle("R9_order_after_stall");

    // R10: withdraw a queued offer by masking, then release it
    offer_ready = 0;
    expect_offer(4'd3, 0, 8'd5);
    pulse(8'h03);
    cfg(1, 4'd1, 8'hFF, 8'd4);
    offer_ready = 1;
    wait_idle("R10_withdraw");
    expect_offer(4'd1, 1, 8'd2);
    cfg(1, 4'd1, 8'd2, 8'd4);
    wait_idle("R10_release");

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule